// File: doc/BRIEF.md
# Three-Axis Acceleration-Integrating Step Generator

This block turns motion segments into step and direction pulses for three stepper axes. A segment gives one signed 16-bit acceleration per axis and a length in clock cycles. While a segment runs, each clock adds the axis acceleration into a 40-bit speed accumulator. The freshly updated speed is then added, in the same cycle, into a 64-bit position accumulator. The host shapes a move entirely through acceleration and time; speed and position are never sent.

The upper bits of each position register form the stepper position. Whenever the chosen step bit (bit 44 by default) changes value, the axis emits one step pulse, and the direction output carries the sign of the speed. One segment may wait behind the running one, so a host that keeps the slot filled gets gap-free motion. When no segment is running, accelerations are zero, so speeds hold and positions keep advancing at the held speed.

Top module: `stepint_gen`

## Requirements
- R1: On every cycle in which a segment runs, each axis speed becomes speed plus its acceleration sign-extended to 40 bits; accelerations sit in seg_accel with axis i at bits [16*i+15:16*i], and the speed accumulator wraps in two's complement.
- R2: In the same cycle, each axis position becomes position plus the updated speed sign-extended to 64 bits. Starting from rest, a run of +1 for 5 cycles, 0 for 5 cycles and -1 for 5 cycles ends at position 50 with speed 0.
- R3: The three axes are independent; each uses only its own acceleration field and owns its own speed and position.
- R4: Each change of position bit STEP_BIT (default 44), in either direction, gives exactly one step_o pulse one cycle high. The pulse appears in the cycle after position_o first shows the new bit value.
- R5: dir_o is 1 when the speed that moved the position was negative and 0 otherwise, and is updated on the same edge as the step pulse it qualifies.
- R6: With no segment running, accelerations count as zero: speed holds its value, position keeps adding that speed each cycle, and busy_o is 0.
- R7: A segment is taken on a rising edge where seg_valid and seg_ready are both 1. One segment may wait behind the running one, and seg_ready is 0 exactly while that waiting slot is full.
- R8: Queued segments run back to back. A segment of length d applies its accelerations on exactly d consecutive cycles, and busy_o stays high across the whole chain with no idle cycle.
- R9: A segment whose seg_cycles is 0 is taken and discarded: it changes no speed or position and does not raise busy_o.
- R10: After a synchronous active-low reset, all speeds and positions are 0, step_o and dir_o are 0, busy_o is 0 and seg_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| seg_valid | input | 1 | Segment offered |
| seg_ready | output | 1 | Segment can be taken this cycle |
| seg_accel | input | N_AXES*ACC_W | Signed acceleration per axis, axis i in slice i |
| seg_cycles | input | DUR_W | Segment length in clock cycles |
| step_o | output | N_AXES | One-cycle step pulse per axis |
| dir_o | output | N_AXES | Direction per axis, 1 for negative speed |
| busy_o | output | 1 | A segment is running or waiting |
| speed_o | output | N_AXES*SPD_W | Speed accumulator per axis |
| position_o | output | N_AXES*POS_W | Position accumulator per axis |

## Verification
A wrong accumulator value does not heal: a speed error shows on speed_o at the next edge, then compounds into position_o every following cycle, and it survives until reset. A lost or duplicated queue cycle leaves a nonzero speed after an accelerate-then-decelerate pair, and the position then drifts at that speed, so the final position misses the closed-form total within a few cycles. A step or direction fault is caught by counting pulses by direction and comparing the count with the number of step-bit changes in the integrated trajectory.

// File: rtl/stepint_pkg.sv
// Shared defaults for the acceleration-integrating step generator.
// Assumes: consumers take these as parameter defaults and may override them.
package stepint_pkg;
    localparam int unsigned DEF_AXES  = 3;
    localparam int unsigned DEF_ACC_W = 16;
    localparam int unsigned DEF_SPD_W = 40;
    localparam int unsigned DEF_POS_W = 64;
    localparam int unsigned DEF_DUR_W = 32;
    localparam int unsigned DEF_STEP  = 44;
endpackage

// File: rtl/stepint_seg_queue.sv
// Segment holder: one running slot with a cycle counter plus one waiting slot.
// Assumes: seg_ready depends only on the waiting slot; zero-length segments are dropped.
module stepint_seg_queue #(
    parameter int unsigned N_AXES = 3,
    parameter int unsigned ACC_W  = 16,
    parameter int unsigned DUR_W  = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    output logic                      in_ready,
    input  logic [N_AXES*ACC_W-1:0]   in_acc,
    input  logic [DUR_W-1:0]          in_dur,
    output logic                      run_o,
    output logic [N_AXES*ACC_W-1:0]   run_acc_o,
    output logic                      busy_o
);
    localparam int unsigned VEC_W = N_AXES * ACC_W;

    logic             act_valid, pend_valid;
    logic [VEC_W-1:0] act_acc, pend_acc;
    logic [DUR_W-1:0] act_cnt, pend_dur;
    logic             take, act_last, act_free;

    // Handshake and end-of-segment decode.
    always_comb begin
        take     = in_valid && in_ready && (in_dur != '0);
        act_last = act_valid && (act_cnt == DUR_W'(1));
        act_free = !act_valid || act_last;
    end

    // Running slot: refill from waiting slot first, else straight from input.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_valid <= 1'b0;
            act_acc   <= '0;
            act_cnt   <= '0;
        end else if (act_free) begin
            if (pend_valid) begin
                act_valid <= 1'b1;
                act_acc   <= pend_acc;
                act_cnt   <= pend_dur;
            end else if (take) begin
                act_valid <= 1'b1;
                act_acc   <= in_acc;
                act_cnt   <= in_dur;
            end else begin
                act_valid <= 1'b0;
            end
        end else begin
            act_cnt <= act_cnt - DUR_W'(1);
        end
    end

    // Waiting slot: filled when the running slot cannot take the input.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_valid <= 1'b0;
            pend_acc   <= '0;
            pend_dur   <= '0;
        end else if (take && !act_free) begin
            pend_valid <= 1'b1;
            pend_acc   <= in_acc;
            pend_dur   <= in_dur;
        end else if (act_free) begin
            pend_valid <= 1'b0;
        end
    end

    assign in_ready  = !pend_valid;
    assign run_o     = act_valid;
    assign run_acc_o = act_acc;
    assign busy_o    = act_valid || pend_valid;

    // R8: a waiting segment takes over with no idle cycle.
    a_r8_no_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (act_last && pend_valid) |=> act_valid);
    // R7: a waiting segment always has a running one ahead of it.
    a_r7_pend_behind_active: assert property (@(posedge clk) disable iff (!rst_n)
        pend_valid |-> act_valid);
    // R9: a zero-length segment offered to an empty holder leaves it empty.
    a_r9_zero_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && in_valid && in_dur == '0) |=> !busy_o);
endmodule

// File: rtl/stepint_axis.sv
// One axis: speed and position accumulators, step-bit change detector, step/dir register.
// Assumes: SPD_W < STEP_BIT so the step bit changes at most once per cycle.
module stepint_axis #(
    parameter int unsigned ACC_W    = 16,
    parameter int unsigned SPD_W    = 40,
    parameter int unsigned POS_W    = 64,
    parameter int unsigned STEP_BIT = 44
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [ACC_W-1:0] acc_i,
    output logic             step_o,
    output logic             dir_o,
    output logic [SPD_W-1:0] spd_o,
    output logic [POS_W-1:0] pos_o
);
    localparam int unsigned SEXT_A = SPD_W - ACC_W;
    localparam int unsigned SEXT_S = POS_W - SPD_W;

    logic [ACC_W-1:0] acc_eff;
    logic [SPD_W-1:0] spd_q, spd_next;
    logic [POS_W-1:0] pos_q, pos_next;
    logic             bit_prev, step_q, dir_q;

    // Double integration; the updated speed feeds position in the same cycle.
    always_comb begin
        acc_eff  = run_i ? acc_i : '0;
        spd_next = spd_q + {{SEXT_A{acc_eff[ACC_W-1]}}, acc_eff};
        pos_next = pos_q + {{SEXT_S{spd_next[SPD_W-1]}}, spd_next};
    end

    // Accumulator registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            spd_q <= '0;
            pos_q <= '0;
        end else begin
            spd_q <= spd_next;
            pos_q <= pos_next;
        end
    end

    // Step pulse on a step-bit change seen one cycle earlier, with the speed sign.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_prev <= 1'b0;
            step_q   <= 1'b0;
            dir_q    <= 1'b0;
        end else begin
            bit_prev <= pos_q[STEP_BIT];
            step_q   <= pos_q[STEP_BIT] ^ bit_prev;
            dir_q    <= spd_q[SPD_W-1];
        end
    end

    assign step_o = step_q;
    assign dir_o  = dir_q;
    assign spd_o  = spd_q;
    assign pos_o  = pos_q;

    // R6: no running segment means the speed does not move.
    a_r6_speed_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> (spd_q == $past(spd_q)));
    // R4: a step-bit change visible on the position is followed by a pulse.
    a_r4_change_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (pos_q[STEP_BIT] != $past(pos_q[STEP_BIT])) |=> step_o);
endmodule

// File: rtl/stepint_gen.sv
// Top: segment holder feeding N_AXES integrating step generators.
// Assumes: axis i acceleration sits in seg_accel slice i; outputs are flat per-axis slices.
module stepint_gen
    import stepint_pkg::*;
#(
    parameter int unsigned N_AXES   = DEF_AXES,
    parameter int unsigned ACC_W    = DEF_ACC_W,
    parameter int unsigned SPD_W    = DEF_SPD_W,
    parameter int unsigned POS_W    = DEF_POS_W,
    parameter int unsigned DUR_W    = DEF_DUR_W,
    parameter int unsigned STEP_BIT = DEF_STEP
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      seg_valid,
    output logic                      seg_ready,
    input  logic [N_AXES*ACC_W-1:0]   seg_accel,
    input  logic [DUR_W-1:0]          seg_cycles,
    output logic [N_AXES-1:0]         step_o,
    output logic [N_AXES-1:0]         dir_o,
    output logic                      busy_o,
    output logic [N_AXES*SPD_W-1:0]   speed_o,
    output logic [N_AXES*POS_W-1:0]   position_o
);
    logic                    run;
    logic [N_AXES*ACC_W-1:0] run_acc;

    stepint_seg_queue #(.N_AXES(N_AXES), .ACC_W(ACC_W), .DUR_W(DUR_W)) u_queue (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (seg_valid),
        .in_ready  (seg_ready),
        .in_acc    (seg_accel),
        .in_dur    (seg_cycles),
        .run_o     (run),
        .run_acc_o (run_acc),
        .busy_o    (busy_o)
    );

    for (genvar g = 0; g < N_AXES; g++) begin : g_axis
        stepint_axis #(.ACC_W(ACC_W), .SPD_W(SPD_W), .POS_W(POS_W), .STEP_BIT(STEP_BIT)) u_axis (
            .clk    (clk),
            .rst_n  (rst_n),
            .run_i  (run),
            .acc_i  (run_acc[g*ACC_W +: ACC_W]),
            .step_o (step_o[g]),
            .dir_o  (dir_o[g]),
            .spd_o  (speed_o[g*SPD_W +: SPD_W]),
            .pos_o  (position_o[g*POS_W +: POS_W])
        );
    end

    // R10: an idle generator always offers a free slot.
    a_r10_idle_ready: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> seg_ready);
endmodule

// File: tb/stepint_gen_tb.sv
module stepint_gen_tb;
    localparam int NA = 3;
    localparam int AW = 16;
    localparam int SW = 40;
    localparam int PW = 64;
    localparam int DW = 32;
    localparam int SB = 8;
    localparam int NV = 6;
    // {acc0, acc1, acc2, cycles}: accelerate phase, then the negated phase
    localparam logic [63:0] VEC [NV] = '{
        {16'sd16,     -16'sd16,    16'sd0,     16'd16},
        {16'sd1,      16'sd2,      16'sd3,     16'd40},
        {-16'sd100,   16'sd50,     16'sd7,     16'd20},
        {16'sd300,    -16'sd1,     16'sd0,     16'd9},
        {16'sd0,      16'sd0,      -16'sd5000, 16'd30},
        {16'sd32767,  -16'sd32767, 16'sd1,     16'd3}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              seg_valid = 1'b0;
    logic              seg_ready;
    logic [NA*AW-1:0]  seg_accel = '0;
    logic [DW-1:0]     seg_cycles = '0;
    logic [NA-1:0]     step_o, dir_o;
    logic              busy_o;
    logic [NA*SW-1:0]  speed_o;
    logic [NA*PW-1:0]  position_o;

    int checks = 0;
    int fails = 0;
    int pcnt [NA];
    int ncnt [NA];

    always #2 clk = ~clk;

    stepint_gen #(.STEP_BIT(SB)) u_dut (
        .clk(clk), .rst_n(rst_n), .seg_valid(seg_valid), .seg_ready(seg_ready),
        .seg_accel(seg_accel), .seg_cycles(seg_cycles), .step_o(step_o),
        .dir_o(dir_o), .busy_o(busy_o), .speed_o(speed_o), .position_o(position_o)
    );

    // Count step pulses by direction, sampled away from the edge.
    always @(negedge clk) begin
        if (rst_n) begin
            for (int i = 0; i < NA; i++) begin
                if (step_o[i]) begin
                    if (dir_o[i]) ncnt[i]++;
                    else          pcnt[i]++;
                end
            end
        end
    end

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic longint spd(input int i);
        return longint'($signed(speed_o[i*SW +: SW]));
    endfunction

    function automatic longint pos(input int i);
        return longint'(position_o[i*PW +: PW]);
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        seg_valid = 1'b0;
        repeat (3) @(negedge clk);
        for (int i = 0; i < NA; i++) begin
            pcnt[i] = 0;
            ncnt[i] = 0;
        end
        rst_n = 1'b1;
    endtask

    task automatic push(input logic [AW-1:0] a0, input logic [AW-1:0] a1,
                        input logic [AW-1:0] a2, input int d);
        @(negedge clk);
        seg_valid  = 1'b1;
        seg_accel  = {a2, a1, a0};
        seg_cycles = DW'(d);
        while (!seg_ready) @(negedge clk);
        @(posedge clk);
    endtask

    task automatic release_wait(output int n);
        @(negedge clk);
        seg_valid = 1'b0;
        n = 0;
        while (busy_o) begin
            n++;
            @(negedge clk);
        end
    endtask

    // Reference trajectory: accelerate d cycles by a, then d cycles by -a.
    task automatic model(input longint a, input int d, output longint s, output longint p,
                         output int np, output int nn);
        longint pn;
        s = 0; p = 0; np = 0; nn = 0;
        for (int ph = 0; ph < 2; ph++) begin
            for (int k = 0; k < d; k++) begin
                s  = s + ((ph == 0) ? a : -a);
                pn = p + s;
                if (pn[SB] != p[SB]) begin
                    if (s < 0) nn++;
                    else       np++;
                end
                p = pn;
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int n;
        // R10: reset state
        do_reset();
        @(negedge clk);
        chk("R10 seg_ready", longint'(seg_ready), 1);
        chk("R10 busy_o", longint'(busy_o), 0);
        chk("R10 step_o", longint'(step_o), 0);
        chk("R10 dir_o", longint'(dir_o), 0);
        for (int i = 0; i < NA; i++) begin
            chk("R10 speed", spd(i), 0);
            chk("R10 position", pos(i), 0);
        end

        // Table walk: accelerate/decelerate pairs back to back (R1 R2 R3 R4 R5 R8)
        for (int e = 0; e < NV; e++) begin
            logic [AW-1:0] av [NA];
            int d;
            for (int i = 0; i < NA; i++) av[i] = VEC[e][63 - 16*i -: 16];
            d = int'(VEC[e][15:0]);
            do_reset();
            push(av[0], av[1], av[2], d);
            push(-av[0], -av[1], -av[2], d);
            release_wait(n);
            chk("R8 busy span", n, 2*d - 1);
            repeat (4) @(negedge clk);
            for (int i = 0; i < NA; i++) begin
                longint es, ep;
                int enp, enn;
                model(longint'($signed(av[i])), d, es, ep, enp, enn);
                chk("R1 final speed", spd(i), es);
                chk("R2 R3 final position", pos(i), ep);
                chk("R4 forward steps", pcnt[i], enp);
                chk("R5 reverse steps", ncnt[i], enn);
            end
        end

        // R2 R7: +1 x5, 0 x5, -1 x5 on axis 0 ends at 50 with speed 0
        do_reset();
        push(16'sd1, 16'sd0, 16'sd0, 5);
        push(16'sd0, 16'sd0, 16'sd0, 5);
        @(negedge clk);
        chk("R7 ready low while slot full", longint'(seg_ready), 0);
        push(-16'sd1, 16'sd0, 16'sd0, 5);
        release_wait(n);
        chk("R8 three segment span", n, 9);
        chk("R2 position 50", pos(0), 50);
        chk("R2 speed 0", spd(0), 0);
        chk("R3 other axis still", pos(1), 0);

        // R6: speed holds after the segment, position keeps moving
        do_reset();
        push(16'sd3, 16'sd3, -16'sd3, 4);
        release_wait(n);
        chk("R1 speed after segment", spd(0), 12);
        chk("R2 position after segment", pos(0), 30);
        chk("R6 busy low", longint'(busy_o), 0);
        repeat (10) @(negedge clk);
        chk("R6 speed held", spd(0), 12);
        chk("R6 position drift", pos(0), 150);
        chk("R6 negative speed held", spd(2), -12);
        chk("R6 negative drift", pos(2), -150);

        // R9: zero-length segment is dropped
        do_reset();
        push(16'sd100, 16'sd100, 16'sd100, 0);
        @(negedge clk);
        seg_valid = 1'b0;
        repeat (3) begin
            chk("R9 busy stays low", longint'(busy_o), 0);
            @(negedge clk);
        end
        chk("R9 speed untouched", spd(1), 0);
        chk("R9 position untouched", pos(1), 0);
        chk("R9 ready", longint'(seg_ready), 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule